// File: doc/BRIEF.md
# Clocked Synchronous Serial Master

This block is a master-only serial port with a clock output (`sck`), a data output (`sdo`) and a data input (`sdi`). The host queues a byte in a one-deep holding register. A controller moves that byte into a shift register and clocks it out as an 8-bit frame with no acknowledge bit. On the same clock edges it captures `sdi`, so every frame also receives a byte. The received byte goes into a receive buffer that the host drains with a read strobe. The bit rate comes from a 16-entry divider table selected by `div_sel`. The host picks the bit order and the clock idle level.

The controller has three states. In `ST_IDLE` the clock rests at its idle level and the divider is held in restart. The transition *start* (`ST_IDLE` to `ST_LEAD`) fires when the holding register is full; the byte moves into the shift register and the bit counter loads 0. `ST_LEAD` is the idle half of a bit cell. The transition *lead* (`ST_LEAD` to `ST_TRAIL`) fires on a divider tick. It moves the clock to its active level and drives the next data bit. `ST_TRAIL` is the active half of the cell. On a tick it takes one of three transitions:
- *next bit* (to `ST_LEAD`): more bits remain in the frame.
- *chain* (to `ST_LEAD`): this was the last bit and another byte is queued. That byte loads at once.
- *finish* (to `ST_IDLE`): this was the last bit and nothing is queued.

Each of these three transitions returns the clock to idle and samples `sdi`.

Top module: `ssx_master`

## Requirements
- R1: After reset, `sck` is at its idle level, `sdo` is 1, `tx_empty` is 1, and `tx_end`, `rx_full`, `overrun` and `bits_left` are 0.
- R2: `div_sel` picks a ratio R from the table 28, 40, 48, 64, 80, 100, 112, 128, 56, 80, 96, 128, 160, 200, 224, 256 (index 0 to 15). Each half of a bit cell lasts H = R >> (SCALE_SHIFT+1) clock cycles, so consecutive leading clock edges are 2H cycles apart.
- R3: With `clk_idle_low` = 0 the clock rests high; with 1 it rests low. Between frames it always returns to that level.
- R4: `sdo` changes only on the edge that leaves the idle level, and it holds until after the following return edge. `sdi` is captured on the return edge.
- R5: `lsb_first` = 0 sends and assembles bit 7 first; `lsb_first` = 1 sends bit 0 first and places the first received bit at bit 0 of `rx_data`.
- R6: `tx_hold_rd` returns the last accepted byte. If `lsb_first` was 1 at write time, the byte is returned bit-reversed.
- R7: `bits_left` is 0 when idle, where 0 means 8 bits remain. After each bit it steps down modulo 8 (7, 6, …, 1, 0).
- R8: An accepted write clears `tx_empty`. The byte moves to the shift register, and `tx_empty` sets again, when a frame starts or chains. A write while the holding register is full is dropped and never sent.
- R9: A byte queued before a frame ends is sent back to back. Its first leading edge comes H cycles after the last return edge, and `tx_end` stays 0.
- R10: `tx_end` sets when a frame finishes with nothing queued. An accepted write clears it.
- R11: `rx_full` sets when a frame completes and is cleared by an `rx_rd` pulse.
- R12: If a frame completes while `rx_full` is 1 and no read occurs in that cycle, `overrun` sets and `rx_data` keeps the older byte. `rx_rd` clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 4 | Bit-rate table index |
| lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| clk_idle_low | input | 1 | 1 = clock rests low, 0 = rests high |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_wdata | input | DATA_W | Byte to queue |
| tx_hold_rd | output | DATA_W | Holding register readback |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | DATA_W | Receive buffer |
| tx_empty | output | 1 | Holding register empty |
| tx_end | output | 1 | Last frame finished, nothing queued |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | A byte was lost while the buffer was full |
| bits_left | output | $clog2(DATA_W) | Bits remaining in the frame (0 = all) |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with DATA_W = 8 and SCALE_SHIFT = 2. This shrinks every half cell to between 3 and 32 cycles. With cells that short, all sixteen divider settings can be measured edge to edge, and every byte value can be sent and received in both bit orders under both idle levels. The bench also runs a chained pair of frames that triggers an overrun and a dropped write, and compares their timing against the same half-cell arithmetic.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    localparam int RATIO_W = 9;
    localparam int SEL_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } ssx_state_e;

    function automatic logic [RATIO_W-1:0] ssx_ratio(input logic [SEL_W-1:0] sel);
        logic [RATIO_W-1:0] r;
        case (sel)
            4'd0:    r = 9'd28;
            4'd1:    r = 9'd40;
            4'd2:    r = 9'd48;
            4'd3:    r = 9'd64;
            4'd4:    r = 9'd80;
            4'd5:    r = 9'd100;
            4'd6:    r = 9'd112;
            4'd7:    r = 9'd128;
            4'd8:    r = 9'd56;
            4'd9:    r = 9'd80;
            4'd10:   r = 9'd96;
            4'd11:   r = 9'd128;
            4'd12:   r = 9'd160;
            4'd13:   r = 9'd200;
            4'd14:   r = 9'd224;
            default: r = 9'd256;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ssx_divider.sv
module ssx_divider
    import ssx_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    localparam int HALF_W = RATIO_W - 1;

    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] scaled;
    logic [HALF_W-1:0]  half_len;
    logic [HALF_W-1:0]  cnt_q;

    // Half-cell length; never allowed to collapse to zero.
    always_comb begin
        ratio    = ssx_ratio(sel);
        scaled   = ratio >> (SCALE_SHIFT + 1);
        half_len = scaled[HALF_W-1:0];
        if (half_len == '0) begin
            half_len = HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || (cnt_q == '0)) begin
            cnt_q <= half_len - HALF_W'(1);
        end else begin
            cnt_q <= cnt_q - HALF_W'(1);
        end
    end

    assign tick = !restart && (cnt_q == '0);

    // R2: consecutive ticks are a full half cell apart.
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (half_len > HALF_W'(1))) |=> !tick);

endmodule

// File: rtl/ssx_txq.sv
module ssx_txq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lsb_first,
    input  logic              take,
    output logic [DATA_W-1:0] hold_q,
    output logic              full_q
);
    logic [DATA_W-1:0] wrev;

    // Stored pre-reversed for LSB-first so the shifter always emits its MSB.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            wrev[i] = wdata[DATA_W-1-i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (wr && !full_q) begin
            hold_q <= lsb_first ? wrev : wdata;
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    // R8: a write arriving while full leaves the queued byte untouched.
    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full_q) |=> $stable(hold_q));

    // R8: the controller only takes a byte that is present.
    a_r8_take_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full_q);

endmodule

// File: rtl/ssx_rxbuf.sv
module ssx_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] frame,
    input  logic              lsb_first,
    input  logic              rd,
    output logic [DATA_W-1:0] data_q,
    output logic              full_q,
    output logic              ovr_q
);
    logic [DATA_W-1:0] frev;
    logic [DATA_W-1:0] value;
    logic              accept;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            frev[i] = frame[DATA_W-1-i];
        end
        value  = lsb_first ? frev : frame;
        accept = done && (!full_q || rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept) begin
                data_q <= value;
                full_q <= 1'b1;
            end else if (rd) begin
                full_q <= 1'b0;
            end
            if (done && full_q && !rd) begin
                ovr_q <= 1'b1;
            end else if (rd) begin
                ovr_q <= 1'b0;
            end
        end
    end

    // R12: on overrun the older byte survives and the flag rises.
    a_r12_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full_q && !rd) |=> ($stable(data_q) && ovr_q));

    // R12: an overrun is only reported alongside an unread byte.
    a_r12_ovr_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> full_q);

endmodule

// File: rtl/ssx_master.sv
module ssx_master
    import ssx_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                div_sel,
    input  logic                      lsb_first,
    input  logic                      clk_idle_low,
    input  logic                      tx_wr,
    input  logic [DATA_W-1:0]         tx_wdata,
    output logic [DATA_W-1:0]         tx_hold_rd,
    input  logic                      rx_rd,
    output logic [DATA_W-1:0]         rx_data,
    output logic                      tx_empty,
    output logic                      tx_end,
    output logic                      rx_full,
    output logic                      overrun,
    output logic [$clog2(DATA_W)-1:0] bits_left,
    output logic                      sck,
    output logic                      sdo,
    input  logic                      sdi
);
    localparam int CNT_W = $clog2(DATA_W);

    ssx_state_e        state_q, state_d;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] rx_word;
    logic [DATA_W-1:0] tx_hold;
    logic [CNT_W-1:0]  bits_q;
    logic              act_q;
    logic              sdo_q;
    logic              tx_end_q;
    logic              tx_full;
    logic              tick;
    logic              restart;
    logic              last_bit;
    logic              done;
    logic              take;

    ssx_divider #(
        .SCALE_SHIFT (SCALE_SHIFT)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (div_sel),
        .restart (restart),
        .tick    (tick)
    );

    ssx_txq #(
        .DATA_W (DATA_W)
    ) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .lsb_first (lsb_first),
        .take      (take),
        .hold_q    (tx_hold),
        .full_q    (tx_full)
    );

    ssx_rxbuf #(
        .DATA_W (DATA_W)
    ) u_rxb (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .frame     (rx_word),
        .lsb_first (lsb_first),
        .rd        (rx_rd),
        .data_q    (rx_data),
        .full_q    (rx_full),
        .ovr_q     (overrun)
    );

    always_comb begin
        restart  = (state_q == ST_IDLE);
        last_bit = (bits_q == CNT_W'(1));
        rx_word  = {shift_q[DATA_W-2:0], sdi};
        done     = (state_q == ST_TRAIL) && tick && last_bit;
        take     = ((state_q == ST_IDLE) && tx_full) || (done && tx_full);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_full) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (tick) state_d = (last_bit && !tx_full) ? ST_IDLE : ST_LEAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            bits_q   <= '0;
            act_q    <= 1'b0;
            sdo_q    <= 1'b1;
            tx_end_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tx_full) begin
                        shift_q <= tx_hold;
                        bits_q  <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        act_q <= 1'b1;
                        sdo_q <= shift_q[DATA_W-1];
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        act_q  <= 1'b0;
                        bits_q <= bits_q - CNT_W'(1);
                        if (last_bit && tx_full) shift_q <= tx_hold;
                        else                     shift_q <= rx_word;
                    end
                end
                default: ;
            endcase
            if (tx_wr && !tx_full) begin
                tx_end_q <= 1'b0;
            end else if (done && !tx_full) begin
                tx_end_q <= 1'b1;
            end
        end
    end

    assign sck        = clk_idle_low ? act_q : ~act_q;
    assign sdo        = sdo_q;
    assign tx_end     = tx_end_q;
    assign tx_empty   = ~tx_full;
    assign tx_hold_rd = tx_hold;
    assign bits_left  = bits_q;

    // R7: the counter rests at its full-frame value between frames.
    a_r7_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (bits_q == '0));

    // R4: clock and data move only on divider ticks.
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(sdo_q) && $stable(act_q)));

    // R3: no active clock level while idle.
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !act_q);

    // R10: transmit end and a queued byte never coexist.
    a_r10_end_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_end_q && tx_full));

endmodule

// File: tb/ssx_master_tb.sv
module ssx_master_tb;

    localparam int SHIFT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] div_sel = 4'd0;
    logic       lsb_first = 1'b0;
    logic       clk_idle_low = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = 8'd0;
    logic [7:0] tx_hold_rd;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       tx_empty, tx_end, rx_full, overrun;
    logic [2:0] bits_left;
    logic       sck, sdo;
    logic       sdi = 1'b0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int epoch = 0;
    int frame_cnt = 0;
    logic [7:0] slave_src [0:2047];
    logic [7:0] got [0:2047];

    ssx_master #(.DATA_W(8), .SCALE_SHIFT(SHIFT)) u_dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .lsb_first(lsb_first),
        .clk_idle_low(clk_idle_low), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_hold_rd(tx_hold_rd), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_empty(tx_empty), .tx_end(tx_end), .rx_full(rx_full),
        .overrun(overrun), .bits_left(bits_left), .sck(sck), .sdo(sdo),
        .sdi(sdi)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_half(input logic [3:0] s);
        int r;
        case (s)
            4'd0: r = 28;   4'd1: r = 40;   4'd2: r = 48;   4'd3: r = 64;
            4'd4: r = 80;   4'd5: r = 100;  4'd6: r = 112;  4'd7: r = 128;
            4'd8: r = 56;   4'd9: r = 80;   4'd10: r = 96;  4'd11: r = 128;
            4'd12: r = 160; 4'd13: r = 200; 4'd14: r = 224; default: r = 256;
        endcase
        return r >> (SHIFT + 1);
    endfunction

    function automatic logic [7:0] brev(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Slave model: watches the serial clock relative to the configured idle level.
    logic prev_act = 1'b0;
    logic cur_act;
    logic lead_sdo = 1'b0;
    logic [7:0] rx_sh = 8'd0;
    int k = 0;
    int last_lead = -1;
    int sl_epoch = -1;

    always @(negedge clk) begin
        cur_act = clk_idle_low ? sck : ~sck;
        if (!rst_n) begin
            prev_act = 1'b0;
            k = 0;
        end else begin
            if (cur_act && !prev_act) begin
                if (sl_epoch == epoch && last_lead >= 0)
                    chk((cyc - last_lead) == 2 * exp_half(div_sel), "R2 lead spacing",
                        cyc - last_lead, 2 * exp_half(div_sel));
                last_lead = cyc;
                sl_epoch = epoch;
                lead_sdo = sdo;
                sdi = lsb_first ? slave_src[frame_cnt][k] : slave_src[frame_cnt][7-k];
            end else if (!cur_act && prev_act) begin
                chk(sdo == lead_sdo, "R4 data held through active half", sdo, lead_sdo);
                rx_sh = {rx_sh[6:0], sdo};
                k++;
                chk(bits_left == 3'((8 - k) & 7), "R7 bits_left", bits_left, (8 - k) & 7);
                if (k == 8) begin
                    got[frame_cnt] = rx_sh;
                    frame_cnt++;
                    k = 0;
                end
            end
            prev_act = cur_act;
        end
    end

    task automatic set_cfg(input logic [3:0] s, input logic ord, input logic pol);
        @(posedge clk);
        #2;
        div_sel = s;
        lsb_first = ord;
        clk_idle_low = pol;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        tx_wdata = b;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic rd_byte();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] w, input logic [7:0] s);
        int idx;
        logic [7:0] exp_wire;
        idx = frame_cnt;
        slave_src[idx] = s;
        epoch++;
        wr_byte(w);
        chk(tx_hold_rd == (lsb_first ? brev(w) : w), "R6 hold readback",
            tx_hold_rd, lsb_first ? brev(w) : w);
        chk(tx_empty == 1'b0, "R8 empty clears on write", tx_empty, 0);
        chk(tx_end == 1'b0, "R10 end clears on write", tx_end, 0);
        while (!tx_end) @(negedge clk);
        @(negedge clk);
        exp_wire = lsb_first ? brev(w) : w;
        chk(frame_cnt == idx + 1, "R5 one frame sent", frame_cnt, idx + 1);
        chk(got[idx] == exp_wire, "R5 wire order", got[idx], exp_wire);
        chk(rx_full == 1'b1, "R11 rx_full sets", rx_full, 1);
        chk(rx_data == s, "R5 receive assembly", rx_data, s);
        chk(tx_empty == 1'b1, "R8 empty after consume", tx_empty, 1);
        chk(sck == ~clk_idle_low, "R3 idle level", sck, ~clk_idle_low);
        rd_byte();
        chk(rx_full == 1'b0, "R11 read clears", rx_full, 0);
    endtask

    initial begin
        #(190000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sck == 1'b1, "R1 sck idle", sck, 1);
        chk(sdo == 1'b1, "R1 sdo", sdo, 1);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(tx_end == 1'b0, "R1 tx_end", tx_end, 0);
        chk(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);
        chk(bits_left == 3'd0, "R1 bits_left", bits_left, 0);

        // R2 divider sweep
        for (int s = 0; s < 16; s++) begin
            set_cfg(4'(s), 1'b0, 1'b0);
            run_frame(8'(s * 17 + 3), 8'hA5 ^ 8'(s));
        end

        // R3/R5/R6 sweep over polarity, order and every byte
        for (int pol = 0; pol < 2; pol++) begin
            for (int ord = 0; ord < 2; ord++) begin
                set_cfg(4'd0, 1'(ord), 1'(pol));
                @(negedge clk);
                chk(sck == ~1'(pol), "R3 idle level after config", sck, ~1'(pol));
                for (int b = 0; b < 256; b++) begin
                    run_frame(8'(b), 8'(b * 37 + ord * 5 + pol));
                end
            end
        end

        // R8/R9/R10/R12 chained frames with overrun and a dropped write
        set_cfg(4'd1, 1'b0, 1'b0);
        base = frame_cnt;
        slave_src[base] = 8'h3C;
        slave_src[base + 1] = 8'hC5;
        slave_src[base + 2] = 8'h81;
        epoch++;
        wr_byte(8'h96);
        while (!tx_empty) @(negedge clk);
        wr_byte(8'h5A);
        chk(tx_hold_rd == 8'h5A, "R8 second byte queued", tx_hold_rd, 8'h5A);
        wr_byte(8'hFF);
        chk(tx_hold_rd == 8'h5A, "R8 write while full dropped", tx_hold_rd, 8'h5A);
        chk(tx_empty == 1'b0, "R8 still full", tx_empty, 0);
        while (frame_cnt < base + 1) @(negedge clk);
        chk(tx_end == 1'b0, "R9 no end between chained frames", tx_end, 0);
        while (!tx_end) @(negedge clk);
        @(negedge clk);
        chk(frame_cnt == base + 2, "R9 two frames", frame_cnt, base + 2);
        chk(got[base] == 8'h96, "R9 first chained byte", got[base], 8'h96);
        chk(got[base + 1] == 8'h5A, "R9 second chained byte", got[base + 1], 8'h5A);
        chk(overrun == 1'b1, "R12 overrun set", overrun, 1);
        chk(rx_full == 1'b1, "R12 buffer still full", rx_full, 1);
        chk(rx_data == 8'h3C, "R12 older byte kept", rx_data, 8'h3C);
        chk(tx_end == 1'b1, "R10 end after last frame", tx_end, 1);
        repeat (200) @(negedge clk);
        chk(frame_cnt == base + 2, "R8 dropped byte never sent", frame_cnt, base + 2);
        rd_byte();
        chk(rx_full == 1'b0, "R11 read clears after overrun", rx_full, 0);
        chk(overrun == 1'b0, "R12 read clears overrun", overrun, 0);
        epoch++;
        wr_byte(8'h11);
        chk(tx_end == 1'b0, "R10 write clears end", tx_end, 0);
        while (!tx_end) @(negedge clk);
        @(negedge clk);
        chk(rx_data == 8'h81, "R11 fresh byte after clear", rx_data, 8'h81);
        chk(overrun == 1'b0, "R12 no overrun when drained", overrun, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule